// File: doc/BRIEF.md
# Caller-ID interrupt and timebase controller

This block merges the event outputs of a caller-ID receiver into a single interrupt line. Four sources feed it. The first is a data-word strobe from an FSK demodulator, with a mark-detect strobe and a reception-active level beside it. The others are a CAS tone strobe, a line polarity-change strobe, and a 32.768 kHz tick from which the block builds a second or minute timebase. Each source that is allowed to fire sets a sticky bit in a status register. The interrupt output is driven in a selectable polarity while any status bit is set.

Two mode registers configure the block, and a small synchronous register bus reaches them and the status register. Reading the status register returns the pending events and clears them. The FSK word interrupt can be held back until a mark period has been seen in the current message. Timebase interrupts can be blocked while FSK reception is in progress. The oscillator-enable bit is not used inside the block and is driven out on a port.

Top module: `cid_irq_ctrl`

## Requirements
- R1: After a synchronous reset both mode registers and the status register read 00h, `osc_en` is 0 and `irq_out` is 1 (the inactive level of the default active-low output).
- R2: Mode register A sits at address 04h, with bit 7 = FSK word enable, bit 6 = mark mask, bit 5 = CAS enable, bit 4 = polarity-change enable and bit 3 = interrupt active high. Mode register B sits at 05h, with bit 7 = oscillator enable, bit 6 = timebase enable, bit 5 = second select (1 = second, 0 = minute) and bit 4 = suppress during FSK. `bus_rdata` holds the addressed value from the clock edge that samples `bus_rd`.
- R3: The reserved bits (bits 2..0 of 04h and bits 3..0 of 05h) read as 0, and writes to them are ignored. A write to the status address 06h changes nothing.
- R4: The status register at 06h has bit 0 = FSK word, bit 1 = CAS, bit 2 = polarity change and bit 3 = timebase, with bits 7..4 reading 0. Its bits are sticky. A read returns them and clears them all, but an event that arrives in the same cycle as the read is kept.
- R5: `irq_out` is at its active level (1 if bit 3 of 04h is set, otherwise 0) while any status bit is set, and at the opposite level otherwise. It follows the status bits one clock later, so a strobe shows on `irq_out` two edges after it is sampled.
- R6: With the mark mask clear, every `fsk_word` strobe sets status bit 0 when the FSK enable is 1. No strobe sets it when the enable is 0.
- R7: With the mark mask set, `fsk_word` sets status bit 0 only if a `fsk_mark` strobe came in an earlier cycle of the current reception. The mark-seen state is cleared when `fsk_active` falls.
- R8: `cas_det` sets status bit 1 only when the CAS enable is 1.
- R9: `pol_chg` sets status bit 2 only when the polarity-change enable is 1.
- R10: With the timebase enabled and second select set, status bit 3 is set once for every TICKS_PER_SEC `tb_tick` strobes.
- R11: With second select clear, status bit 3 is set once for every TICKS_PER_SEC*SEC_PER_MIN `tb_tick` strobes.
- R12: While the timebase enable is 0 the tick and second counters stay at zero. A re-enabled timebase counts a full period before its first event.
- R13: While the suppress bit is 1 and `fsk_active` is 1, timebase events set no status bit. With the suppress bit 0 they do.
- R14: `osc_en` equals bit 7 of mode register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| fsk_word | input | 1 | One-cycle strobe: FSK data word received |
| fsk_mark | input | 1 | One-cycle strobe: mark period detected |
| fsk_active | input | 1 | Level: FSK reception in progress |
| cas_det | input | 1 | One-cycle strobe: CAS tone detected |
| pol_chg | input | 1 | One-cycle strobe: line polarity changed |
| tb_tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| osc_en | output | 1 | Oscillator enable from mode register B |
| irq_out | output | 1 | Interrupt output, polarity selectable |

## Verification
The bench goes after the mark mask across two receptions. A design that kept the mark-seen state after `fsk_active` falls would let the first channel-seizure word of the next message interrupt. It also issues a status read in the same cycle as a CAS strobe, which a design that cleared after setting would lose. The timebase is disabled partway through a second and restarted, and the minute period is counted to the exact tick, so a counter that is not cleared, or that wraps one tick early, shows up as an early or missing status bit. Reserved and status-address writes are checked by reading the registers back, and the polarity bit is flipped while events are pending to catch an inverted or unregistered interrupt level.

// File: rtl/cid_irq_pkg.sv
package cid_irq_pkg;
  localparam int FLAG_N  = 4;
  localparam int FLG_FSK = 0;
  localparam int FLG_CAS = 1;
  localparam int FLG_POL = 2;
  localparam int FLG_TB  = 3;

  typedef struct packed {
    logic fsk_en;
    logic mark_mask;
    logic cas_en;
    logic pol_en;
    logic irq_hi;
  } mode_a_t;

  typedef struct packed {
    logic osc_en;
    logic tb_en;
    logic sec_sel;
    logic tb_sup;
  } mode_b_t;
endpackage

// File: rtl/cid_mode_regs.sv
module cid_mode_regs
  import cid_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int MODEA_ADDR = 4,
  parameter int MODEB_ADDR = 5,
  parameter int STAT_ADDR  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_N-1:0] flags,
  output mode_a_t           mode_a,
  output mode_b_t           mode_b,
  output logic [DATA_W-1:0] rdata,
  output logic              stat_rd
);
  localparam int MA_W = $bits(mode_a_t);
  localparam int MB_W = $bits(mode_b_t);

  logic hit_a, hit_b, hit_s;
  assign hit_a   = (addr == ADDR_W'(MODEA_ADDR));
  assign hit_b   = (addr == ADDR_W'(MODEB_ADDR));
  assign hit_s   = (addr == ADDR_W'(STAT_ADDR));
  assign stat_rd = rd && hit_s;

  // Only the defined upper bits are stored; reserved bits have no flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_a <= '0;
      mode_b <= '0;
    end else if (wr) begin
      if (hit_a) mode_a <= mode_a_t'(wdata[DATA_W-1 -: MA_W]);
      if (hit_b) mode_b <= mode_b_t'(wdata[DATA_W-1 -: MB_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_a)      rdata <= {mode_a, {(DATA_W-MA_W){1'b0}}};
      else if (hit_b) rdata <= {mode_b, {(DATA_W-MB_W){1'b0}}};
      else if (hit_s) rdata <= {{(DATA_W-FLAG_N){1'b0}}, flags};
      else            rdata <= '0;
    end
  end
endmodule

// File: rtl/cid_timebase.sv
module cid_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sec_sel,
  input  logic tick_in,
  output logic evt,
  output logic idle
);
  localparam int SUB_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic [SUB_W-1:0] sub_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic sec_wrap, min_wrap;

  assign sec_wrap = en && tick_in && (sub_cnt == SUB_W'(TICKS_PER_SEC-1));
  assign min_wrap = sec_wrap && (sec_cnt == SEC_W'(SEC_PER_MIN-1));
  assign evt      = sec_sel ? sec_wrap : min_wrap;
  assign idle     = (sub_cnt == '0) && (sec_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sub_cnt <= '0;
      sec_cnt <= '0;
    end else if (tick_in) begin
      sub_cnt <= sec_wrap ? '0 : sub_cnt + 1'b1;
      if (sec_wrap) sec_cnt <= min_wrap ? '0 : sec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cid_event_flags.sv
module cid_event_flags
  import cid_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  mode_a_t           mode_a,
  input  logic              tb_sup,
  input  logic              fsk_word,
  input  logic              fsk_mark,
  input  logic              fsk_active,
  input  logic              cas_det,
  input  logic              pol_chg,
  input  logic              tb_evt,
  input  logic              clr,
  output logic [FLAG_N-1:0] flags,
  output logic              mark_seen
);
  logic act_q;
  logic rx_end;
  logic [FLAG_N-1:0] set_vec;

  assign rx_end = act_q && !fsk_active;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_FSK] = mode_a.fsk_en && fsk_word && (!mode_a.mark_mask || mark_seen);
    set_vec[FLG_CAS] = mode_a.cas_en && cas_det;
    set_vec[FLG_POL] = mode_a.pol_en && pol_chg;
    set_vec[FLG_TB]  = tb_evt && !(tb_sup && fsk_active);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      mark_seen <= 1'b0;
    end else begin
      act_q <= fsk_active;
      if (rx_end)        mark_seen <= 1'b0;
      else if (fsk_mark) mark_seen <= 1'b1;
    end
  end

  // Set wins over the read-clear so a coincident event is not lost.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr)        flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cid_irq_ctrl.sv
module cid_irq_ctrl
  import cid_irq_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int MODEA_ADDR    = 4,
  parameter int MODEB_ADDR    = 5,
  parameter int STAT_ADDR     = 6,
  parameter int TICKS_PER_SEC = 32768,
  parameter int SEC_PER_MIN   = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fsk_word,
  input  logic              fsk_mark,
  input  logic              fsk_active,
  input  logic              cas_det,
  input  logic              pol_chg,
  input  logic              tb_tick,
  output logic              osc_en,
  output logic              irq_out
);
  mode_a_t           mode_a;
  mode_b_t           mode_b;
  logic              stat_rd;
  logic [FLAG_N-1:0] flags;
  logic              mark_seen;
  logic              tb_evt;
  logic              tb_idle;

  cid_mode_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MODEA_ADDR(MODEA_ADDR), .MODEB_ADDR(MODEB_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .flags(flags), .mode_a(mode_a), .mode_b(mode_b),
    .rdata(bus_rdata), .stat_rd(stat_rd)
  );

  cid_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)
  ) u_tb (
    .clk(clk), .rst(rst), .en(mode_b.tb_en), .sec_sel(mode_b.sec_sel),
    .tick_in(tb_tick), .evt(tb_evt), .idle(tb_idle)
  );

  cid_event_flags u_flags (
    .clk(clk), .rst(rst), .mode_a(mode_a), .tb_sup(mode_b.tb_sup),
    .fsk_word(fsk_word), .fsk_mark(fsk_mark), .fsk_active(fsk_active),
    .cas_det(cas_det), .pol_chg(pol_chg), .tb_evt(tb_evt), .clr(stat_rd),
    .flags(flags), .mark_seen(mark_seen)
  );

  assign osc_en = mode_b.osc_en;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b1;
    else     irq_out <= mode_a.irq_hi ? (|flags) : !(|flags);
  end
endmodule

// File: rtl/cid_irq_checker.sv
module cid_irq_checker
  import cid_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int MODEA_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input mode_a_t           mode_a,
  input mode_b_t           mode_b,
  input logic [FLAG_N-1:0] flags,
  input logic              mark_seen,
  input logic              fsk_active,
  input logic              stat_rd,
  input logic              fsk_word,
  input logic              cas_det,
  input logic              pol_chg,
  input logic              tb_evt,
  input logic              tb_idle,
  input logic              irq_out
);
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(MODEA_ADDR)) |=> (bus_rdata[2:0] == 3'b000));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !fsk_word && !cas_det && !pol_chg && !tb_evt) |=> (flags == '0));

  assert_irq_active_R5: assert property (@(posedge clk) disable iff (rst)
    ((|flags) && !stat_rd && mode_a.irq_hi) |=> irq_out);

  assert_mark_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_a.mark_mask && !mark_seen && !flags[FLG_FSK]) |=> !flags[FLG_FSK]);

  assert_cas_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (!mode_a.cas_en && !flags[FLG_CAS]) |=> !flags[FLG_CAS]);

  assert_pol_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!mode_a.pol_en && !flags[FLG_POL]) |=> !flags[FLG_POL]);

  assert_tb_reset_R12: assert property (@(posedge clk) disable iff (rst)
    !mode_b.tb_en |=> tb_idle);

  assert_tb_sup_R13: assert property (@(posedge clk) disable iff (rst)
    (mode_b.tb_sup && fsk_active && !flags[FLG_TB]) |=> !flags[FLG_TB]);
endmodule

bind cid_irq_ctrl cid_irq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODEA_ADDR(MODEA_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .mode_a(mode_a), .mode_b(mode_b), .flags(flags),
  .mark_seen(mark_seen), .fsk_active(fsk_active), .stat_rd(stat_rd),
  .fsk_word(fsk_word), .cas_det(cas_det), .pol_chg(pol_chg),
  .tb_evt(tb_evt), .tb_idle(tb_idle), .irq_out(irq_out)
);

// File: tb/sim_cid_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cid_irq_ctrl;
  localparam int TPS = 4;
  localparam int SPM = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       fsk_word = 1'b0, fsk_mark = 1'b0, fsk_active = 1'b0;
  logic       cas_det = 1'b0, pol_chg = 1'b0, tb_tick = 1'b0;
  logic       osc_en, irq_out;

  always #2.5 clk = ~clk;

  cid_irq_ctrl #(.TICKS_PER_SEC(TPS), .SEC_PER_MIN(SPM)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fsk_word(fsk_word), .fsk_mark(fsk_mark), .fsk_active(fsk_active),
    .cas_det(cas_det), .pol_chg(pol_chg), .tb_tick(tb_tick),
    .osc_en(osc_en), .irq_out(irq_out)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic rd_q = 1'b0;

  always @(posedge clk) rd_q <= bus_rd;

  // Monitor: read data is valid from the edge that sampled bus_rd.
  always @(negedge clk) begin
    if (rd_q) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read data %02h with no expected item", bus_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          fails++;
          $display("FAIL %s: rdata actual %02h expected %02h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tb_tick = 1'b1;
      @(negedge clk); tb_tick = 1'b0;
    end
  endtask

  task automatic tb_restart(input logic [7:0] v);
    wr(8'h05, 8'h00);
    wr(8'h05, v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq_out, 1'b1, "R1 irq idle");
    chk(osc_en, 1'b0, "R1 osc_en");
    rd(8'h04, 8'h00, "R1 mode A");
    rd(8'h05, 8'h00, "R1 mode B");
    rd(8'h06, 8'h00, "R1 status");

    // R2 / R3 register map and reserved bits, R14 oscillator bit
    wr(8'h04, 8'hFF);
    rd(8'h04, 8'hF8, "R3 mode A reserved");
    wr(8'h05, 8'hFF);
    rd(8'h05, 8'hF0, "R3 mode B reserved");
    chk(osc_en, 1'b1, "R14 osc_en set");
    wr(8'h04, 8'h00);
    wr(8'h05, 8'h00);
    chk(osc_en, 1'b0, "R14 osc_en clear");
    wr(8'h06, 8'hFF);
    rd(8'h06, 8'h00, "R3 status write ignored");
    wr(8'h04, 8'hA8);
    rd(8'h04, 8'hA8, "R2 mode A readback");
    wr(8'h04, 8'h00);

    // R8 CAS gating, R4 sticky/clear, R5 active low
    @(negedge clk); cas_det = 1'b1; @(negedge clk); cas_det = 1'b0;
    @(negedge clk);
    chk(irq_out, 1'b1, "R8 cas disabled no irq");
    rd(8'h06, 8'h00, "R8 cas disabled");
    wr(8'h04, 8'h20);
    @(negedge clk); cas_det = 1'b1; @(negedge clk); cas_det = 1'b0;
    @(negedge clk);
    chk(irq_out, 1'b0, "R5 active low asserted");
    rd(8'h06, 8'h02, "R4 cas flag");
    @(negedge clk);
    chk(irq_out, 1'b1, "R5 released after read");
    rd(8'h06, 8'h00, "R4 cleared by read");

    // R5 active high, R9 polarity-change gating
    wr(8'h04, 8'h38);
    @(negedge clk);
    chk(irq_out, 1'b0, "R5 active high idle");
    @(negedge clk); pol_chg = 1'b1; @(negedge clk); pol_chg = 1'b0;
    @(negedge clk);
    chk(irq_out, 1'b1, "R5 active high asserted");
    wr(8'h04, 8'h30);
    @(negedge clk);
    chk(irq_out, 1'b0, "R5 polarity flip while pending");
    rd(8'h06, 8'h04, "R9 pol flag");
    wr(8'h04, 8'h28);
    @(negedge clk); pol_chg = 1'b1; @(negedge clk); pol_chg = 1'b0;
    rd(8'h06, 8'h00, "R9 pol disabled");

    // R6 FSK enable, mask clear
    wr(8'h04, 8'h80);
    fsk_active = 1'b1;
    @(negedge clk); fsk_word = 1'b1; @(negedge clk); fsk_word = 1'b0;
    rd(8'h06, 8'h01, "R6 word unmasked");
    wr(8'h04, 8'h00);
    @(negedge clk); fsk_word = 1'b1; @(negedge clk); fsk_word = 1'b0;
    rd(8'h06, 8'h00, "R6 fsk disabled");
    fsk_active = 1'b0;

    // R7 mark mask across two receptions
    wr(8'h04, 8'hC0);
    @(negedge clk); fsk_active = 1'b1;
    @(negedge clk); fsk_word = 1'b1; @(negedge clk); fsk_word = 1'b0;
    rd(8'h06, 8'h00, "R7 seizure word masked");
    @(negedge clk); fsk_mark = 1'b1; @(negedge clk); fsk_mark = 1'b0;
    @(negedge clk); fsk_word = 1'b1; @(negedge clk); fsk_word = 1'b0;
    rd(8'h06, 8'h01, "R7 word after mark");
    @(negedge clk); fsk_active = 1'b0;
    @(negedge clk); fsk_active = 1'b1;
    @(negedge clk); fsk_word = 1'b1; @(negedge clk); fsk_word = 1'b0;
    rd(8'h06, 8'h00, "R7 mark cleared at end of reception");
    @(negedge clk); fsk_active = 1'b0;

    // R4 event coincident with read is kept
    wr(8'h04, 8'h20);
    begin
      exp_t it;
      it.val = 8'h00; it.tag = "R4 coincident read old value";
      exp_q.push_back(it);
    end
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h06; cas_det = 1'b1;
    @(negedge clk); bus_rd = 1'b0; cas_det = 1'b0;
    rd(8'h06, 8'h02, "R4 coincident event kept");
    wr(8'h04, 8'h00);

    // R10 second tick
    tb_restart(8'h60);
    ticks(TPS - 1);
    rd(8'h06, 8'h00, "R10 before second");
    ticks(1);
    rd(8'h06, 8'h08, "R10 second event");

    // R12 disable resets counters
    ticks(2);
    tb_restart(8'h60);
    ticks(TPS - 1);
    rd(8'h06, 8'h00, "R12 full period after restart");
    ticks(1);
    rd(8'h06, 8'h08, "R12 event after restart");

    // R11 minute tick
    tb_restart(8'h40);
    ticks(TPS * SPM - 1);
    rd(8'h06, 8'h00, "R11 before minute");
    ticks(1);
    rd(8'h06, 8'h08, "R11 minute event");

    // R13 suppression during FSK reception
    tb_restart(8'h70);
    @(negedge clk); fsk_active = 1'b1;
    ticks(TPS);
    rd(8'h06, 8'h00, "R13 suppressed");
    @(negedge clk); fsk_active = 1'b0;
    ticks(TPS);
    rd(8'h06, 8'h08, "R13 allowed when idle");
    tb_restart(8'h60);
    @(negedge clk); fsk_active = 1'b1;
    ticks(TPS);
    rd(8'h06, 8'h08, "R13 suppress bit clear");
    @(negedge clk); fsk_active = 1'b0;

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule